// File: doc/BRIEF.md
# Tiered-Reset Configuration Register File

This block holds the 512-byte configuration space of a managed flash card controller. The host changes bytes through a byte-addressed write port when a switch-style command has been decoded. The host reads the space back through a byte-addressed read port when it asks for the extended register dump. The upper part of the space, addresses 192 to 511, is a fixed properties area. The lower part, addresses 0 to 191, holds modes. Each modes byte is given an access class. The class decides whether the host may write the byte, whether a read returns its contents, and which reset events clear it.

Three reset events arrive on separate inputs: a power cycle (`por_n` low), a hardware reset pin request (`hw_rst_req`), and a software reset command (`sw_rst`). The pin request is gated by the low two bits of byte 162. When the request is honoured, the block pulses `pre_idle`. Values that must survive resets are held in ordinary flops, and only the power input clears them.

Top module: `cfg_tiered_regfile`

## Requirements
- R1: Addresses 192..511 are read-only and return fixed values (192 reads 06h, 196 reads 17h, 200 reads 05h, 502 reads 01h, 503 reads 03h, 504 reads 01h, all others 00h). A write there is refused.
- R2: Persistent bytes 131, 177 and 179 keep their value through a pin reset and a software reset. A power cycle clears them to 00h.
- R3: Volatile bytes 33, 183, 185, 187 and 191 return to 00h on any of the three reset events.
- R4: Write-after-clear bytes 171, 173 and 178 accept one write and are then locked. A software reset neither clears nor unlocks them. A power cycle or an honoured pin reset clears them to 00h and unlocks them.
- R5: One-time bytes 155, 156, 162, 167 and 169 accept a single write, and any later write is refused. They keep their value through pin and software resets, and only a power cycle clears them.
- R6: Write-only bytes 32, 164 and 165 accept writes, always read 00h, and are reset like volatile bytes.
- R7: `hw_rst_req` has no effect unless byte 162 bits [1:0] equal 01. When it is honoured, `pre_idle` is high for the one cycle after the request.
- R8: Byte 183, which selects the data bus width, reads 00h (single-line transfer) after a power cycle or an honoured pin reset.
- R9: The following always read zero: modes bytes that have no class listed above, byte 162 bits [7:2], byte 183 bits [7:4], and byte 179 bit 7. A write to a reserved byte is refused.
- R10: `wr_mode` selects how a write is applied: 00 replaces the byte, 01 ORs the data into it, 10 clears the bits set in the data, and 11 is refused.
- R11: A refused write leaves every byte unchanged and raises `switch_error` for exactly the cycle after the write. An accepted write does not raise it.
- R12: `rd_valid` is high in the cycle after `rd_en`, with `rd_data` holding the addressed byte as it stood at that edge.
- R13: A write issued in the same cycle as a reset event has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-cycle reset, active low, synchronous |
| hw_rst_req | input | 1 | Hardware reset pin request, gated by byte 162 |
| sw_rst | input | 1 | Software reset command pulse |
| wr_en | input | 1 | Write strobe |
| wr_mode | input | 2 | Write mode: 00 write, 01 set, 10 clear, 11 refused |
| wr_addr | input | 9 | Write byte address |
| wr_data | input | 8 | Write data or bit mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 9 | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read byte |
| switch_error | output | 1 | One-cycle pulse for a refused write |
| pre_idle | output | 1 | One-cycle pulse when a pin reset is honoured |

## Verification
The bench goes after the reset matrix. Each class is written, then hit with each reset event, then read back. A design that mixed up the reset domains would lose persistent values on a software reset, or keep write-after-clear locks across a pin reset. The lock rules are tested with repeated writes. A broken lock would overwrite one-time bytes, or let a write-after-clear byte change after a software reset. The pin gate is tested with byte 162 both clear and set. An ungated pin would wipe volatile bytes and pulse `pre_idle` on its default setting. Reserved bits, write-only readback, the set and clear modes, and a write that collides with a reset are each checked through the read port.

// File: rtl/cfg_tier_pkg.sv
package cfg_tier_pkg;
  localparam int CFG_ADDR_W     = 9;
  localparam int CFG_MODE_BYTES = 192;

  typedef enum logic [2:0] {
    AC_RSVD, AC_RO, AC_VOL, AC_PERS, AC_WAC, AC_OTP, AC_WO
  } acc_class_e;

  function automatic acc_class_e class_of(input logic [CFG_ADDR_W-1:0] a);
    if (a >= CFG_ADDR_W'(CFG_MODE_BYTES)) return AC_RO;
    case (a)
      9'd33, 9'd183, 9'd185, 9'd187, 9'd191: return AC_VOL;
      9'd131, 9'd177, 9'd179:                return AC_PERS;
      9'd171, 9'd173, 9'd178:                return AC_WAC;
      9'd155, 9'd156, 9'd162, 9'd167, 9'd169: return AC_OTP;
      9'd32, 9'd164, 9'd165:                 return AC_WO;
      default:                               return AC_RSVD;
    endcase
  endfunction

  function automatic logic [7:0] wmask_of(input logic [CFG_ADDR_W-1:0] a);
    case (a)
      9'd162: return 8'h03;
      9'd183: return 8'h0F;
      9'd179: return 8'h7F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rom_of(input logic [CFG_ADDR_W-1:0] a);
    case (a)
      9'd192: return 8'h06;
      9'd196: return 8'h17;
      9'd200: return 8'h05;
      9'd502: return 8'h01;
      9'd503: return 8'h03;
      9'd504: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_wr_merge.sv
module cfg_wr_merge (
  input  logic [1:0] mode,
  input  logic [7:0] cur,
  input  logic [7:0] wdata,
  input  logic [7:0] mask,
  output logic [7:0] merged,
  output logic       mode_ok
);
  logic [7:0] raw;
  always_comb begin
    mode_ok = 1'b1;
    case (mode)
      2'b00:   raw = wdata;
      2'b01:   raw = cur | wdata;
      2'b10:   raw = cur & ~wdata;
      default: begin raw = cur; mode_ok = 1'b0; end
    endcase
    merged = raw & mask;
  end
endmodule

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell
  import cfg_tier_pkg::*;
#(
  parameter acc_class_e CLS = AC_VOL
) (
  input  logic       clk,
  input  logic       por,
  input  logic       hw,
  input  logic       sw,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic       locked
);
  localparam bit HW_KEEPS = (CLS == AC_PERS) || (CLS == AC_OTP);
  localparam bit SW_CLRS  = (CLS == AC_VOL) || (CLS == AC_WO);
  localparam bit LOCKS    = (CLS == AC_WAC) || (CLS == AC_OTP);

  always_ff @(posedge clk) begin
    if (por) begin
      q      <= 8'h00;
      locked <= 1'b0;
    end else if (hw && !HW_KEEPS) begin
      q      <= 8'h00;
      locked <= 1'b0;
    end else if (sw && SW_CLRS) begin
      q      <= 8'h00;
    end else if (we) begin
      q <= wdata;
      if (LOCKS) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_tiered_regfile.sv
module cfg_tiered_regfile
  import cfg_tier_pkg::*;
#(
  parameter int ADDR_W     = CFG_ADDR_W,
  parameter int MODE_BYTES = CFG_MODE_BYTES,
  parameter int HWRST_BYTE = 162
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst_req,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              switch_error,
  output logic              pre_idle
);
  localparam int IDX_W = $clog2(MODE_BYTES);

  logic [7:0] q  [MODE_BYTES];
  logic       lk [MODE_BYTES];

  logic por, hw_fire, any_rst;
  assign por     = ~por_n;
  assign hw_fire = hw_rst_req && (q[HWRST_BYTE][1:0] == 2'b01);
  assign any_rst = por | hw_fire | sw_rst;

  // write decode
  logic             wr_in_modes;
  logic [IDX_W-1:0] widx;
  logic [7:0]       wcur, merged;
  logic             mode_ok, accept;
  acc_class_e       wcls;

  assign wr_in_modes = wr_addr < ADDR_W'(MODE_BYTES);
  assign widx        = wr_addr[IDX_W-1:0];
  assign wcls        = class_of(wr_addr);
  assign wcur        = wr_in_modes ? q[widx] : 8'h00;

  cfg_wr_merge u_merge (
    .mode    (wr_mode),
    .cur     (wcur),
    .wdata   (wr_data),
    .mask    (wmask_of(wr_addr)),
    .merged  (merged),
    .mode_ok (mode_ok)
  );

  always_comb begin
    accept = 1'b0;
    if (wr_en && mode_ok && wr_in_modes && !any_rst) begin
      case (wcls)
        AC_VOL, AC_PERS, AC_WO: accept = 1'b1;
        AC_WAC, AC_OTP:         accept = !lk[widx];
        default:                accept = 1'b0;
      endcase
    end
  end

  // per-byte storage, one cell per classed byte
  for (genvar i = 0; i < MODE_BYTES; i++) begin : g_byte
    localparam acc_class_e CLS_I = class_of(ADDR_W'(i));
    if (CLS_I == AC_RSVD) begin : g_rsvd
      assign q[i]  = 8'h00;
      assign lk[i] = 1'b0;
    end else begin : g_cell
      cfg_byte_cell #(.CLS(CLS_I)) u_cell (
        .clk    (clk),
        .por    (por),
        .hw     (hw_fire),
        .sw     (sw_rst),
        .we     (accept && (wr_addr == ADDR_W'(i))),
        .wdata  (merged),
        .q      (q[i]),
        .locked (lk[i])
      );
    end
  end

  // read path
  logic [7:0] rd_comb;
  always_comb begin
    case (class_of(rd_addr))
      AC_RO:            rd_comb = rom_of(rd_addr);
      AC_RSVD, AC_WO:   rd_comb = 8'h00;
      default:          rd_comb = q[rd_addr[IDX_W-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      rd_valid     <= 1'b0;
      rd_data      <= 8'h00;
      switch_error <= 1'b0;
      pre_idle     <= 1'b0;
    end else begin
      rd_valid     <= rd_en;
      if (rd_en) rd_data <= rd_comb;
      switch_error <= wr_en && !accept && !any_rst;
      pre_idle     <= hw_fire;
    end
  end
endmodule

// File: rtl/cfg_tiered_regfile_chk.sv
module cfg_tiered_regfile_chk #(
  parameter int ADDR_W     = 9,
  parameter int MODE_BYTES = 192,
  parameter int HWRST_BYTE = 162
) (
  input logic              clk,
  input logic              por_n,
  input logic              hw_rst_req,
  input logic              sw_rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [7:0]        rd_data,
  input logic              switch_error,
  input logic              pre_idle
);
  p_rd_lat_r12: assert property (@(posedge clk) disable iff (!por_n)
    rd_en |=> rd_valid);
  p_rd_idle_r12: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |=> !rd_valid);
  p_err_cause_r11: assert property (@(posedge clk) disable iff (!por_n)
    switch_error |-> $past(wr_en));
  p_ro_refused_r1: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_addr >= ADDR_W'(MODE_BYTES) && !hw_rst_req && !sw_rst) |=> switch_error);
  p_preidle_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
    pre_idle |-> $past(hw_rst_req));
  p_rsvd_bits_r9: assert property (@(posedge clk) disable iff (!por_n)
    (rd_en && rd_addr == ADDR_W'(HWRST_BYTE)) |=> (rd_data[7:2] == 6'd0));
  p_sw_no_err_r13: assert property (@(posedge clk) disable iff (!por_n)
    sw_rst |=> !switch_error);
endmodule

bind cfg_tiered_regfile cfg_tiered_regfile_chk #(
  .ADDR_W(ADDR_W), .MODE_BYTES(MODE_BYTES), .HWRST_BYTE(HWRST_BYTE)
) u_chk (
  .clk(clk), .por_n(por_n), .hw_rst_req(hw_rst_req), .sw_rst(sw_rst),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_data(rd_data), .switch_error(switch_error),
  .pre_idle(pre_idle)
);

// File: tb/test_cfg_tiered_regfile.sv
module test_cfg_tiered_regfile;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, hw_rst_req = 1'b0, sw_rst = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_mode = 2'b00;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_valid, switch_error, pre_idle;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  cfg_tiered_regfile i_cfg_tiered_regfile (
    .clk(clk), .por_n(por_n), .hw_rst_req(hw_rst_req), .sw_rst(sw_rst),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .switch_error(switch_error), .pre_idle(pre_idle)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), int'(rd_data), exp_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic rd(input int a, input int exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; rd_addr = 9'(a);
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, input int m, input int exp_err, input string tag);
    wr_en = 1; wr_addr = 9'(a); wr_data = 8'(d); wr_mode = 2'(m);
    @(negedge clk);
    wr_en = 0;
    check({tag, " switch_error"}, int'(switch_error), exp_err);
  endtask

  task automatic do_por();
    por_n = 0; @(negedge clk); @(negedge clk); por_n = 1; @(negedge clk);
  endtask

  task automatic do_hw(input int exp_pulse);
    hw_rst_req = 1; @(negedge clk); hw_rst_req = 0;
    check("R7 pre_idle", int'(pre_idle), exp_pulse);
    @(negedge clk);
  endtask

  task automatic do_sw();
    sw_rst = 1; @(negedge clk); sw_rst = 0; @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_por();
    check("R12 reset rd_valid", int'(rd_valid), 0);
    check("R11 reset switch_error", int'(switch_error), 0);
    rd(192, 'h06, "R1 ro 192");
    rd(196, 'h17, "R1 ro 196");
    rd(504, 'h01, "R1 ro 504");
    rd(183, 'h00, "R8 bus width after power");
    rd(162, 'h00, "R5 otp default");
    wr(200, 'hFF, 0, 1, "R1 write ro");
    rd(200, 'h05, "R1 ro unchanged");

    wr(187, 'h5A, 0, 0, "R10 write");
    wr(187, 'h81, 1, 0, "R10 set");
    rd(187, 'hDB, "R10 set result");
    wr(187, 'h0A, 2, 0, "R10 clear");
    wr(187, 'hFF, 3, 1, "R10 mode 11");
    rd(187, 'hD1, "R11 unchanged after refused");

    wr(182, 'hFF, 0, 1, "R9 reserved write");
    rd(182, 'h00, "R9 reserved reads 0");
    wr(183, 'hFF, 0, 0, "R9 bus width");
    rd(183, 'h0F, "R9 bus width masked");
    wr(179, 'hFF, 0, 0, "R9 byte 179");
    rd(179, 'h7F, "R9 byte 179 masked");

    wr(165, 'hAA, 0, 0, "R6 wo write");
    rd(165, 'h00, "R6 wo reads 0");

    wr(178, 'h33, 0, 0, "R4 first write");
    wr(178, 'h44, 0, 1, "R4 locked write");
    rd(178, 'h33, "R4 value kept");
    do_sw();
    rd(178, 'h33, "R4 kept over sw reset");
    wr(178, 'h44, 0, 1, "R4 still locked after sw");

    wr(169, 'h12, 0, 0, "R5 first write");
    wr(169, 'h34, 0, 1, "R5 second write");
    rd(169, 'h12, "R5 value kept");

    wr(177, 'h9C, 0, 0, "R2 write");
    do_sw();
    rd(177, 'h9C, "R2 kept over sw");
    rd(187, 'h00, "R3 cleared by sw");
    rd(183, 'h00, "R3 bus width cleared by sw");

    wr(187, 'h66, 0, 0, "R3 rewrite");
    do_hw(0);
    rd(187, 'h66, "R7 pin ignored by default");

    wr(162, 'hFD, 0, 0, "R5 enable pin");
    rd(162, 'h01, "R9 162 reserved bits");
    wr(183, 'h02, 0, 0, "R8 set width");
    do_hw(1);
    check("R7 pre_idle one cycle", int'(pre_idle), 0);
    rd(187, 'h00, "R3 cleared by pin");
    rd(183, 'h00, "R8 bus width after pin");
    rd(177, 'h9C, "R2 kept over pin");
    rd(178, 'h00, "R4 cleared by pin");
    wr(178, 'h55, 0, 0, "R4 unlocked by pin");
    rd(178, 'h55, "R4 rewritten");
    rd(169, 'h12, "R5 kept over pin");
    rd(162, 'h01, "R5 enable kept");

    wr(191, 'h11, 0, 0, "R3 write 191");
    sw_rst = 1; wr_en = 1; wr_addr = 9'd191; wr_data = 8'h22; wr_mode = 2'b00;
    @(negedge clk);
    sw_rst = 0; wr_en = 0;
    check("R13 no error on collision", int'(switch_error), 0);
    rd(191, 'h00, "R13 write lost to reset");

    do_por();
    rd(177, 'h00, "R2 cleared by power");
    rd(169, 'h00, "R5 cleared by power");
    wr(169, 'h77, 0, 0, "R5 writable after power");
    rd(169, 'h77, "R5 new value");
    rd(162, 'h00, "R5 enable cleared by power");
    do_hw(0);

    repeat (3) @(negedge clk);
    check("R12 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule